// File: doc/BRIEF.md
# Fewest-in-Flight Fetch Chooser with Quiesce

This block decides which hardware thread owns the fetch slot of a simultaneous-multithreading core in each cycle. Every thread has a saturating count of its instructions in flight. The count rises when the thread is granted a slot and falls when the back end reports that one of its instructions has retired or been squashed. Among the threads that may fetch, the one with the lowest count wins. When counts tie, the winner is the first tied thread in round-robin order after the thread granted last.

A spin-waiting thread can take itself out of scheduling. It first arms a watch on the memory line it polls, then issues a quiesce. From then on it gets no fetch slot until the snooped write stream shows a write to that line. Matching is done on an aligned line address, so a write at any offset inside the line counts. A write that reaches the armed line before the quiesce cancels the watch, so no wakeup is lost in that window. When all other threads are asleep, the one awake thread receives every slot.

Top module: `smt_fetch_chooser`

## Requirements
- R1: While `fetch_en_i` is high and at least one thread is awake, `grant_valid_o` is high in the same cycle and names the awake thread with the lowest in-flight count. While `fetch_en_i` is low, or while all threads are asleep, `grant_valid_o` is low.
- R2: Threads with equal lowest counts are served in round-robin order, starting with the thread after the one granted last. After reset, thread 0 is served first.
- R3: A thread's count goes up by one at each clock edge where it holds a valid grant. It goes down by one at each edge where its `retire_i` bit is high. When both happen at the same edge, the count does not change.
- R4: Counts are 6 bits wide and saturate. An increment at 63 leaves the count at 63, and a decrement at 0 leaves it at 0.
- R5: An arm request records the line address of `arm_addr_i` (the bits above the low 6 bits, for 64-byte lines) for thread `arm_tid_i`. A quiesce from an armed thread sets its `asleep_o` bit after the next edge, and that thread then receives no grant.
- R6: A snooped write whose line address equals a sleeping thread's armed line clears that thread's `asleep_o` bit after the next edge. The write may land at any byte offset in the line. A write to any other line leaves the thread asleep.
- R7: A quiesce from a thread with no armed line has no effect. A wakeup clears the armed state, so a second quiesce without a new arm has no effect.
- R8: A write to the armed line that arrives before the quiesce cancels the watch, and the later quiesce then has no effect.
- R9: When only one thread is awake and `fetch_en_i` is high, that thread is granted every cycle.
- R10: While `rst_ni` is low, all counts clear to 0, all watches clear, and the round-robin pointer is set so that thread 0 is next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_en_i | input | 1 | A fetch slot is available this cycle |
| retire_i | input | NTHREADS | One bit per thread: one instruction of that thread retired or was squashed |
| arm_valid_i | input | 1 | Arm a watch for `arm_tid_i` |
| arm_tid_i | input | TID_W | Thread that is arming |
| arm_addr_i | input | ADDR_W | Address to watch |
| quiesce_valid_i | input | 1 | Quiesce request |
| quiesce_tid_i | input | TID_W | Thread that is quiescing |
| snoop_valid_i | input | 1 | A snooped write is present this cycle |
| snoop_addr_i | input | ADDR_W | Address of the snooped write |
| grant_valid_o | output | 1 | The fetch slot is granted this cycle |
| grant_tid_o | output | TID_W | Thread that holds the grant |
| asleep_o | output | NTHREADS | One bit per thread: the thread is quiesced |

## Verification
Saturation is the hardest behaviour to reach from the ports. The counts can only be seen through the thread the chooser picks, and a count only climbs far when one thread fetches alone. The stimulus therefore puts the other three threads to sleep and gives the lone thread exactly 64 grants. It then wakes the others and checks that the saturated thread stays last in the order. A wrapping counter would have returned to 0 and been picked again. The lower limit is checked the same way: a thread that is retired past zero must still be picked ahead of threads whose count is 1.

// File: rtl/fetch_chooser_pkg.sv
`timescale 1ns/1ps
package fetch_chooser_pkg;
  typedef enum logic [1:0] {
    WATCH_IDLE   = 2'd0,
    WATCH_ARMED  = 2'd1,
    WATCH_ASLEEP = 2'd2
  } watch_state_e;
endpackage

// File: rtl/inflight_ctr.sv
`timescale 1ns/1ps
module inflight_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case ({inc_i, dec_i})
        2'b10: if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
        2'b01: if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/watch_slot.sv
`timescale 1ns/1ps
module watch_slot
  import fetch_chooser_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [LINE_W-1:0] arm_line_i,
  input  logic              quiesce_i,
  input  logic              snoop_i,
  input  logic [LINE_W-1:0] snoop_line_i,
  output logic              asleep_o
);
  watch_state_e      state_q, state_d;
  logic [LINE_W-1:0] line_q;
  logic              hit;

  assign hit = snoop_i && (state_q != WATCH_IDLE) && (snoop_line_i == line_q);

  // arm wins over a same-cycle hit; a hit before quiesce cancels the watch
  always_comb begin
    state_d = state_q;
    if (arm_i)                                  state_d = WATCH_ARMED;
    else if (hit)                               state_d = WATCH_IDLE;
    else if (quiesce_i && state_q == WATCH_ARMED) state_d = WATCH_ASLEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WATCH_IDLE;
      line_q  <= '0;
    end else begin
      state_q <= state_d;
      if (arm_i) line_q <= arm_line_i;
    end
  end

  assign asleep_o = (state_q == WATCH_ASLEEP);
endmodule

// File: rtl/fewest_pick.sv
`timescale 1ns/1ps
module fewest_pick #(
  parameter int NTHREADS = 4,
  parameter int CNT_W    = 6,
  parameter int TID_W    = 2
) (
  input  logic [NTHREADS*CNT_W-1:0] counts_i,
  input  logic [NTHREADS-1:0]       eligible_i,
  input  logic [TID_W-1:0]          last_i,
  input  logic                      req_i,
  output logic                      valid_o,
  output logic [TID_W-1:0]          tid_o
);
  logic             found;
  logic [CNT_W-1:0] best_cnt;
  logic [TID_W-1:0] best_tid;

  // scan in round-robin order after last_i; strict < keeps the first tied thread
  always_comb begin
    found    = 1'b0;
    best_cnt = '1;
    best_tid = '0;
    for (int k = 1; k <= NTHREADS; k++) begin
      int unsigned idx;
      idx = (int'(last_i) + k) % NTHREADS;
      if (eligible_i[idx] && (!found || counts_i[idx*CNT_W +: CNT_W] < best_cnt)) begin
        found    = 1'b1;
        best_cnt = counts_i[idx*CNT_W +: CNT_W];
        best_tid = TID_W'(idx);
      end
    end
  end

  assign valid_o = req_i && found;
  assign tid_o   = best_tid;
endmodule

// File: rtl/smt_fetch_chooser.sv
`timescale 1ns/1ps
module smt_fetch_chooser #(
  parameter  int NTHREADS   = 4,
  parameter  int ADDR_W     = 32,
  parameter  int CNT_W      = 6,
  parameter  int LINE_BYTES = 64,
  localparam int TID_W      = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fetch_en_i,
  input  logic [NTHREADS-1:0] retire_i,
  input  logic                arm_valid_i,
  input  logic [TID_W-1:0]    arm_tid_i,
  input  logic [ADDR_W-1:0]   arm_addr_i,
  input  logic                quiesce_valid_i,
  input  logic [TID_W-1:0]    quiesce_tid_i,
  input  logic                snoop_valid_i,
  input  logic [ADDR_W-1:0]   snoop_addr_i,
  output logic                grant_valid_o,
  output logic [TID_W-1:0]    grant_tid_o,
  output logic [NTHREADS-1:0] asleep_o
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;

  logic [NTHREADS*CNT_W-1:0] counts;
  logic [NTHREADS-1:0]       asleep;
  logic [TID_W-1:0]          last_q;
  logic                      gnt_v;
  logic [TID_W-1:0]          gnt_tid;

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thread
    inflight_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (gnt_v && (gnt_tid == TID_W'(t))),
      .dec_i   (retire_i[t]),
      .count_o (counts[t*CNT_W +: CNT_W])
    );

    watch_slot #(.LINE_W(LINE_W)) u_watch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .arm_i        (arm_valid_i && (arm_tid_i == TID_W'(t))),
      .arm_line_i   (arm_addr_i[ADDR_W-1:OFF_W]),
      .quiesce_i    (quiesce_valid_i && (quiesce_tid_i == TID_W'(t))),
      .snoop_i      (snoop_valid_i),
      .snoop_line_i (snoop_addr_i[ADDR_W-1:OFF_W]),
      .asleep_o     (asleep[t])
    );
  end

  fewest_pick #(.NTHREADS(NTHREADS), .CNT_W(CNT_W), .TID_W(TID_W)) u_pick (
    .counts_i   (counts),
    .eligible_i (~asleep),
    .last_i     (last_q),
    .req_i      (fetch_en_i),
    .valid_o    (gnt_v),
    .tid_o      (gnt_tid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= TID_W'(NTHREADS - 1);
    else if (gnt_v) last_q <= gnt_tid;
  end

  assign grant_valid_o = gnt_v;
  assign grant_tid_o   = gnt_tid;
  assign asleep_o      = asleep;
endmodule

// File: rtl/smt_fetch_chooser_chk.sv
`timescale 1ns/1ps
module smt_fetch_chooser_chk #(
  parameter int NTHREADS = 4,
  parameter int ADDR_W   = 32,
  parameter int TID_W    = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fetch_en_i,
  input logic                arm_valid_i,
  input logic [TID_W-1:0]    arm_tid_i,
  input logic                quiesce_valid_i,
  input logic [TID_W-1:0]    quiesce_tid_i,
  input logic                snoop_valid_i,
  input logic                grant_valid_o,
  input logic [TID_W-1:0]    grant_tid_o,
  input logic [NTHREADS-1:0] asleep_o
);
  // R1
  grant_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> !asleep_o[grant_tid_o]);
  // R1
  no_slot_no_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_en_i |-> !grant_valid_o);
  // R9
  slot_used_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_en_i && !(&asleep_o)) |-> grant_valid_o);
  // R1
  tid_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (int'(grant_tid_o) < NTHREADS));

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    // R5
    sleep_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(asleep_o[t]) |-> $past(quiesce_valid_i && (quiesce_tid_i == TID_W'(t))));
    // R6
    wake_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(asleep_o[t]) |-> $past(snoop_valid_i || (arm_valid_i && (arm_tid_i == TID_W'(t)))));
  end
endmodule

bind smt_fetch_chooser smt_fetch_chooser_chk #(
  .NTHREADS(NTHREADS), .ADDR_W(ADDR_W), .TID_W(TID_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fetch_en_i      (fetch_en_i),
  .arm_valid_i     (arm_valid_i),
  .arm_tid_i       (arm_tid_i),
  .quiesce_valid_i (quiesce_valid_i),
  .quiesce_tid_i   (quiesce_tid_i),
  .snoop_valid_i   (snoop_valid_i),
  .grant_valid_o   (grant_valid_o),
  .grant_tid_o     (grant_tid_o),
  .asleep_o        (asleep_o)
);

// File: tb/smt_fetch_chooser_test.sv
`timescale 1ns/1ps
module smt_fetch_chooser_test;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_en;
  logic [N-1:0] retire;
  logic        arm_v;
  logic [1:0]  arm_tid;
  logic [31:0] arm_addr;
  logic        q_v;
  logic [1:0]  q_tid;
  logic        sn_v;
  logic [31:0] sn_addr;
  logic        gnt_v;
  logic [1:0]  gnt_tid;
  logic [N-1:0] asleep;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smt_fetch_chooser uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_en_i(fetch_en), .retire_i(retire),
    .arm_valid_i(arm_v), .arm_tid_i(arm_tid), .arm_addr_i(arm_addr),
    .quiesce_valid_i(q_v), .quiesce_tid_i(q_tid),
    .snoop_valid_i(sn_v), .snoop_addr_i(sn_addr),
    .grant_valid_o(gnt_v), .grant_tid_o(gnt_tid), .asleep_o(asleep)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_grant(input string req, input int tid);
    chk(req, "grant", {30'd0, gnt_v, 1'b0} | 32'(gnt_tid) << 4, 32'h2 | (tid << 4));
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    fetch_en = 0; retire = '0; arm_v = 0; arm_tid = 0; arm_addr = 0;
    q_v = 0; q_tid = 0; sn_v = 0; sn_addr = 0;
  endtask

  task automatic apply_reset();
    idle();
    rst_n = 0;
    cyc(); cyc();
    rst_n = 1;
    #1;
  endtask

  task automatic arm(input int tid, input logic [31:0] a);
    arm_v = 1; arm_tid = 2'(tid); arm_addr = a; cyc(); arm_v = 0;
  endtask

  task automatic quiesce(input int tid);
    q_v = 1; q_tid = 2'(tid); cyc(); q_v = 0;
  endtask

  task automatic snoop(input logic [31:0] a);
    sn_v = 1; sn_addr = a; cyc(); sn_v = 0;
  endtask

  task automatic t_reset();
    apply_reset();
    // R10
    chk("R10", "asleep after reset", 32'(asleep), 32'h0);
    chk("R1", "no grant while fetch disabled", 32'(gnt_v), 32'h0);
    fetch_en = 1; #1;
    expect_grant("R10", 0);
  endtask

  task automatic t_round_robin();
    apply_reset();
    fetch_en = 1; #1;
    // R2 equal counts rotate
    for (int i = 0; i < 8; i++) begin
      expect_grant("R2", i % 4);
      cyc();
    end
  endtask

  task automatic t_fewest();
    apply_reset();
    fetch_en = 1;
    for (int i = 0; i < 8; i++) cyc();
    fetch_en = 0;
    retire[2] = 1; cyc(); cyc(); retire = '0;
    fetch_en = 1; #1;
    // R1 lowest count wins over round-robin order
    expect_grant("R1", 2); cyc();
    expect_grant("R1", 2); cyc();
    expect_grant("R2", 3); cyc();
    expect_grant("R2", 0); cyc();
    // R3 grant and retire on the same edge cancel
    expect_grant("R3", 1); retire[1] = 1; cyc(); retire = '0;
    expect_grant("R3", 2); cyc();
    expect_grant("R3", 1); cyc();
  endtask

  task automatic t_saturate();
    apply_reset();
    for (int t = 1; t < 4; t++) begin
      arm(t, 32'h1000 * t);
      quiesce(t);
    end
    chk("R5", "three asleep", 32'(asleep), 32'he);
    fetch_en = 1; #1;
    // R9 lone thread takes every slot
    for (int i = 0; i < 64; i++) begin
      expect_grant("R9", 0);
      cyc();
    end
    fetch_en = 0;
    for (int t = 1; t < 4; t++) snoop(32'h1000 * t + 32'h4);
    chk("R6", "all woken", 32'(asleep), 32'h0);
    fetch_en = 1; #1;
    // R4 count held at 63, so thread 0 stays behind
    for (int i = 0; i < 6; i++) begin
      expect_grant("R4", (i % 3) + 1);
      cyc();
    end
  endtask

  task automatic t_underflow();
    apply_reset();
    fetch_en = 1;
    for (int i = 0; i < 4; i++) cyc();
    fetch_en = 0;
    retire[0] = 1; cyc(); cyc(); retire = '0;
    fetch_en = 1; #1;
    // R4 decrement at zero holds zero
    expect_grant("R4", 0); cyc();
    expect_grant("R4", 1); cyc();
  endtask

  task automatic t_quiesce();
    apply_reset();
    quiesce(2);
    // R7 unarmed quiesce is ignored
    chk("R7", "unarmed quiesce", 32'(asleep), 32'h0);
    arm(1, 32'h4000_0080);
    chk("R5", "arm alone no sleep", 32'(asleep), 32'h0);
    quiesce(1);
    chk("R5", "armed quiesce sleeps", 32'(asleep), 32'h2);
    fetch_en = 1; #1;
    for (int i = 0; i < 6; i++) begin
      expect_grant("R5", (i % 3 == 0) ? 0 : (i % 3) + 1);
      cyc();
    end
    fetch_en = 0;
    snoop(32'h4000_00C0);
    chk("R6", "other line no wake", 32'(asleep), 32'h2);
    snoop(32'h4000_00BC);
    chk("R6", "same line wakes", 32'(asleep), 32'h0);
    quiesce(1);
    chk("R7", "wake cleared arm", 32'(asleep), 32'h0);
  endtask

  task automatic t_early_write();
    apply_reset();
    arm(3, 32'h0000_0800);
    snoop(32'h0000_0810);
    quiesce(3);
    // R8
    chk("R8", "early write cancels watch", 32'(asleep), 32'h0);
  endtask

  task automatic t_all_asleep();
    apply_reset();
    for (int t = 0; t < 4; t++) begin
      arm(t, 32'h2000_0000 + 32'h40 * t);
      quiesce(t);
    end
    fetch_en = 1; #1;
    chk("R1", "no grant when all asleep", 32'(gnt_v), 32'h0);
    fetch_en = 0;
    snoop(32'h2000_0080);
    fetch_en = 1; #1;
    expect_grant("R9", 2);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    t_reset();
    t_round_robin();
    t_fewest();
    t_saturate();
    t_underflow();
    t_quiesce();
    t_early_write();
    t_all_asleep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule